// File: doc/BRIEF.md
# Video RAM Block Transfer Engine

This block copies data from anywhere in the system address space into video RAM. Software loads a source and a destination through four byte-wide address registers. It then writes a control byte that gives the length and the pacing. Two pacings exist. A general transfer moves the whole length in one burst. A blank-paced transfer moves one 16-byte block each time the video timing enters its horizontal-blank mode. The processor is stalled for the length of every burst. While it is stalled, the engine drives a read strobe and then a write strobe for each byte on the system bus.

Once a burst is finished, the advanced source and destination are stored back into the address registers. The control byte then reports the progress. In blank-paced mode it counts down by one for each block. After a general transfer, or after the last paced block, it reads 0xFF. Register writes are blocked while a burst is running, because the processor that issues them is stalled.

Top module: `vdma_engine`

## Requirements
- R1: The start source is the source byte pair (high byte at select 0, low byte at select 1) with its low four bits cleared. The start destination is the destination pair (selects 2 and 3) masked to bits 12..4 and then ORed with 0x8000.
- R2: A control write (select 4) whose masked source lies in 0x8000–0x9FFF starts no burst and leaves the address registers and the paced-mode arming unchanged. The control readback becomes the written value with bit 7 set.
- R3: A control write with bit 7 clear starts a general burst at once when paced mode is not armed. The burst moves ((value & 0x7F) + 1) × 16 bytes.
- R4: Each byte takes two cycles. In the first cycle the read strobe is high with the current source address. In the second cycle the write strobe is high with the current destination address and the data returned by the bus in that cycle. Both addresses then advance by one.
- R5: The stall output is high in exactly the cycles of a burst, and no bus strobe is driven outside them.
- R6: When a burst ends, the advanced source and destination are written back to the four address registers, where readback shows them.
- R7: A finished general burst sets the control readback to 0xFF.
- R8: A control write with bit 7 set arms paced mode. A 16-byte block starts at once if the video mode input is 0, and otherwise on each entry into video mode 0. Each finished block decrements the control byte. When the byte wraps to 0xFF, paced mode disarms.
- R9: Arming paced mode while the LCD-enable input is low makes the control readback 0x80 | ((value + 1) & 0x7F). Any other accepted control write reads back as value & 0x7F.
- R10: After reset the engine is idle, the stall is low, the control readback is 0xFF, the address registers read 0x00, and paced mode is disarmed.
- R11: A control write with bit 7 clear, made while paced mode is armed and the video mode is not 0, starts nothing and disarms paced mode. A later entry into mode 0 starts no block.
- R12: Register writes made while the stall is high have no effect. A control write during a burst neither lengthens nor restarts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Write select: 0 src high, 1 src low, 2 dst high, 3 dst low, 4 control |
| reg_wdata | input | 8 | Register write data |
| rd_sel | input | 3 | Readback select, same encoding; other codes read 0xFF |
| rd_data | output | 8 | Readback data |
| video_mode | input | 2 | Current video mode; 0 is horizontal blank |
| lcd_on | input | 1 | LCD enable |
| bus_rd_en | output | 1 | Bus read strobe |
| bus_rd_addr | output | 16 | Bus read address |
| bus_rd_data | input | 8 | Read data, valid in the cycle after the read strobe |
| bus_wr_en | output | 1 | Bus write strobe |
| bus_wr_addr | output | 16 | Bus write address |
| bus_wr_data | output | 8 | Bus write data |
| cpu_stall | output | 1 | Processor stall, high during a burst |

## Verification
The bench uses the default parameters: 16-byte blocks and an 8 KiB video window based at 0x8000. With these values the address masks, the rejection window and the 0x7F length field are the exact ones a bus-side model can predict byte for byte. This brings within reach the control-byte wrap at the last paced block, and a destination whose high bits are cut off by the mask. The longest general burst is 2048 bytes (4096 stall cycles), which is short enough to run in full.

// File: rtl/vdma_pkg.sv
// Shared types for the video RAM transfer engine.
// Assumes a 16-bit byte-addressed system bus with 8-bit data.
package vdma_pkg;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned LEN_W  = BYTE_W - 1;

    typedef enum logic [2:0] {
        SEL_SRC_HI = 3'd0,
        SEL_SRC_LO = 3'd1,
        SEL_DST_HI = 3'd2,
        SEL_DST_LO = 3'd3,
        SEL_CTRL   = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
    } addr_pair_t;

    localparam logic [BYTE_W-1:0] CTRL_DONE = 8'hFF;
endpackage

// File: rtl/vdma_regs.sv
// Register file of the transfer engine: four address bytes, the control
// byte and the paced-mode arming flag. It applies the launch decisions and
// the end-of-burst write-back. Assumes wr_en is already blocked during bursts,
// so write-back and software writes never coincide.
module vdma_regs
    import vdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [2:0]        rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              ctrl_load,
    input  logic [BYTE_W-1:0] ctrl_next,
    input  logic              arm_load,
    input  logic              arm_next,
    input  logic              blk_done,
    input  addr_pair_t        done_addr,
    output logic [ADDR_W-1:0] src_word,
    output logic [ADDR_W-1:0] dst_word,
    output logic              armed
);
    localparam int unsigned N_ADDR = 4;

    logic [BYTE_W-1:0] addr_view [N_ADDR];
    logic [BYTE_W-1:0] wb_byte   [N_ADDR];
    logic [BYTE_W-1:0] ctrl_q;
    logic [BYTE_W-1:0] ctrl_dec;

    // Split the advanced addresses into the byte order of the selects
    assign wb_byte[0] = done_addr.src[ADDR_W-1:BYTE_W];
    assign wb_byte[1] = done_addr.src[BYTE_W-1:0];
    assign wb_byte[2] = done_addr.dst[ADDR_W-1:BYTE_W];
    assign wb_byte[3] = done_addr.dst[BYTE_W-1:0];

    generate
        for (genvar i = 0; i < N_ADDR; i++) begin : g_addr
            logic [BYTE_W-1:0] q;
            // Hold one address byte: write-back wins, else software write
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (blk_done) begin
                    q <= wb_byte[i];
                end else if (wr_en && wr_sel == 3'(i)) begin
                    q <= wr_data;
                end
            end
            assign addr_view[i] = q;
        end
    endgenerate

    assign src_word = {addr_view[0], addr_view[1]};
    assign dst_word = {addr_view[2], addr_view[3]};
    assign ctrl_dec = ctrl_q - 8'd1;

    // Control byte and arming: countdown on paced blocks, 0xFF on general ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_DONE;
            armed  <= 1'b0;
        end else if (blk_done) begin
            if (armed) begin
                ctrl_q <= ctrl_dec;
                if (ctrl_dec == CTRL_DONE) begin
                    armed <= 1'b0;
                end
            end else begin
                ctrl_q <= CTRL_DONE;
            end
        end else begin
            if (ctrl_load) begin
                ctrl_q <= ctrl_next;
            end
            if (arm_load) begin
                armed <= arm_next;
            end
        end
    end

    // Readback multiplexer
    always_comb begin
        if (rd_sel < 3'(N_ADDR)) begin
            rd_data = addr_view[rd_sel[1:0]];
        end else if (rd_sel == SEL_CTRL) begin
            rd_data = ctrl_q;
        end else begin
            rd_data = CTRL_DONE;
        end
    end
endmodule

// File: rtl/vdma_launch.sv
// Launch decoder: turns a control write or a horizontal-blank entry into a
// burst request, and works out the new control byte and arming state.
// Assumes ctrl_wr is only asserted while no burst runs.
module vdma_launch
    import vdma_pkg::*;
#(
    parameter int unsigned       BLOCK_LOG2 = 4,
    parameter logic [ADDR_W-1:0] VRAM_BASE  = 16'h8000,
    parameter int unsigned       VRAM_LOG2  = 13,
    parameter int unsigned       CNT_W      = LEN_W + 1 + BLOCK_LOG2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] src_word,
    input  logic [ADDR_W-1:0] dst_word,
    input  logic              armed,
    input  logic              busy,
    input  logic [1:0]        video_mode,
    input  logic              lcd_on,
    output logic              start,
    output addr_pair_t        start_addr,
    output logic [CNT_W-1:0]  start_bytes,
    output logic              ctrl_load,
    output logic [BYTE_W-1:0] ctrl_next,
    output logic              arm_load,
    output logic              arm_next
);
    localparam logic [ADDR_W-1:0] LOW_MASK  = ADDR_W'((32'd1 << BLOCK_LOG2) - 32'd1);
    localparam logic [ADDR_W-1:0] BLK_MASK  = ~LOW_MASK;
    localparam logic [ADDR_W-1:0] SPAN_MASK = ADDR_W'((32'd1 << VRAM_LOG2) - 32'd1);
    localparam logic [ADDR_W-1:0] DST_MASK  = SPAN_MASK & BLK_MASK;
    localparam logic [CNT_W-1:0]  BLK_BYTES = CNT_W'(1) << BLOCK_LOG2;

    logic [ADDR_W-1:0] src_m;
    logic [ADDR_W-1:0] dst_m;
    logic              src_bad;
    logic              mode_zero;
    logic              prev_zero;
    logic              entering;
    logic [CNT_W-1:0]  gen_bytes;

    assign src_m     = src_word & BLK_MASK;
    assign dst_m     = (dst_word & DST_MASK) | VRAM_BASE;
    assign src_bad   = (src_m & ~SPAN_MASK) == VRAM_BASE;
    assign mode_zero = (video_mode == 2'd0);
    assign entering  = mode_zero && !prev_zero;
    assign gen_bytes = (CNT_W'(wdata[LEN_W-1:0]) + CNT_W'(1)) << BLOCK_LOG2;

    // Remember whether the previous cycle was already in blank mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_zero <= 1'b1;
        end else begin
            prev_zero <= mode_zero;
        end
    end

    // Decide launch, length and the control/arming updates
    always_comb begin
        start       = 1'b0;
        start_addr  = '{src: src_m, dst: dst_m};
        start_bytes = BLK_BYTES;
        ctrl_load   = 1'b0;
        ctrl_next   = wdata;
        arm_load    = 1'b0;
        arm_next    = 1'b0;
        if (ctrl_wr) begin
            ctrl_load = 1'b1;
            if (src_bad) begin
                ctrl_next = wdata | 8'h80;
            end else begin
                arm_load = 1'b1;
                arm_next = wdata[BYTE_W-1];
                if ((!armed && !wdata[BYTE_W-1]) || mode_zero) begin
                    start       = 1'b1;
                    start_bytes = wdata[BYTE_W-1] ? BLK_BYTES : gen_bytes;
                    ctrl_next   = {1'b0, wdata[LEN_W-1:0]};
                end else if (wdata[BYTE_W-1] && !lcd_on) begin
                    ctrl_next = {1'b1, wdata[LEN_W-1:0] + 7'd1};
                end else begin
                    ctrl_next = {1'b0, wdata[LEN_W-1:0]};
                end
            end
        end else if (armed && entering && !busy) begin
            start       = 1'b1;
            start_bytes = BLK_BYTES;
        end
    end
endmodule

// File: rtl/vdma_mover.sv
// Byte mover: a read phase followed by a write phase for each byte, with the
// source and destination advancing after the write. Assumes bus read data
// is valid in the cycle after the read strobe.
module vdma_mover
    import vdma_pkg::*;
#(
    parameter int unsigned CNT_W = 12
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  addr_pair_t        start_addr,
    input  logic [CNT_W-1:0]  start_bytes,
    input  logic [BYTE_W-1:0] bus_rd_data,
    output logic              busy,
    output logic              bus_rd_en,
    output logic [ADDR_W-1:0] bus_rd_addr,
    output logic              bus_wr_en,
    output logic [ADDR_W-1:0] bus_wr_addr,
    output logic [BYTE_W-1:0] bus_wr_data,
    output logic              blk_done,
    output addr_pair_t        done_addr
);
    phase_e           phase_q;
    addr_pair_t       cur_q;
    logic [CNT_W-1:0] left_q;
    logic             last_byte;

    assign last_byte = (left_q == CNT_W'(1));
    assign done_addr = '{src: cur_q.src + 16'd1, dst: cur_q.dst + 16'd1};

    // Step through idle, read and write phases, counting bytes down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cur_q   <= '0;
            left_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        cur_q   <= start_addr;
                        left_q  <= start_bytes;
                        phase_q <= PH_READ;
                    end
                end
                PH_READ: begin
                    phase_q <= PH_WRITE;
                end
                PH_WRITE: begin
                    cur_q   <= done_addr;
                    left_q  <= left_q - CNT_W'(1);
                    phase_q <= last_byte ? PH_IDLE : PH_READ;
                end
                default: begin
                    phase_q <= PH_IDLE;
                end
            endcase
        end
    end

    // Bus strobes follow the phase directly
    always_comb begin
        busy        = (phase_q != PH_IDLE);
        bus_rd_en   = (phase_q == PH_READ);
        bus_rd_addr = cur_q.src;
        bus_wr_en   = (phase_q == PH_WRITE);
        bus_wr_addr = cur_q.dst;
        bus_wr_data = bus_rd_data;
        blk_done    = (phase_q == PH_WRITE) && last_byte;
    end
endmodule

// File: rtl/vdma_engine.sv
// Top of the video RAM transfer engine. It joins the register file, the
// launch decoder and the byte mover, and stalls the processor while bytes
// move. Assumes the stalled processor cannot issue register writes, so
// writes during a burst are dropped here.
module vdma_engine
    import vdma_pkg::*;
#(
    parameter int unsigned       BLOCK_LOG2 = 4,
    parameter logic [ADDR_W-1:0] VRAM_BASE  = 16'h8000,
    parameter int unsigned       VRAM_LOG2  = 13
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_sel,
    input  logic [7:0]  reg_wdata,
    input  logic [2:0]  rd_sel,
    output logic [7:0]  rd_data,
    input  logic [1:0]  video_mode,
    input  logic        lcd_on,
    output logic        bus_rd_en,
    output logic [15:0] bus_rd_addr,
    input  logic [7:0]  bus_rd_data,
    output logic        bus_wr_en,
    output logic [15:0] bus_wr_addr,
    output logic [7:0]  bus_wr_data,
    output logic        cpu_stall
);
    localparam int unsigned CNT_W = LEN_W + 1 + BLOCK_LOG2;

    logic              busy;
    logic              wr_ok;
    logic              ctrl_wr;
    logic [ADDR_W-1:0] src_word;
    logic [ADDR_W-1:0] dst_word;
    logic              armed;
    logic              start;
    addr_pair_t        start_addr;
    logic [CNT_W-1:0]  start_bytes;
    logic              ctrl_load;
    logic [BYTE_W-1:0] ctrl_next;
    logic              arm_load;
    logic              arm_next;
    logic              blk_done;
    addr_pair_t        done_addr;

    assign wr_ok     = reg_wr && !busy;
    assign ctrl_wr   = wr_ok && (reg_sel == SEL_CTRL);
    assign cpu_stall = busy;

    vdma_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_ok),
        .wr_sel    (reg_sel),
        .wr_data   (reg_wdata),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .ctrl_load (ctrl_load),
        .ctrl_next (ctrl_next),
        .arm_load  (arm_load),
        .arm_next  (arm_next),
        .blk_done  (blk_done),
        .done_addr (done_addr),
        .src_word  (src_word),
        .dst_word  (dst_word),
        .armed     (armed)
    );

    vdma_launch #(
        .BLOCK_LOG2 (BLOCK_LOG2),
        .VRAM_BASE  (VRAM_BASE),
        .VRAM_LOG2  (VRAM_LOG2),
        .CNT_W      (CNT_W)
    ) u_launch (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (ctrl_wr),
        .wdata       (reg_wdata),
        .src_word    (src_word),
        .dst_word    (dst_word),
        .armed       (armed),
        .busy        (busy),
        .video_mode  (video_mode),
        .lcd_on      (lcd_on),
        .start       (start),
        .start_addr  (start_addr),
        .start_bytes (start_bytes),
        .ctrl_load   (ctrl_load),
        .ctrl_next   (ctrl_next),
        .arm_load    (arm_load),
        .arm_next    (arm_next)
    );

    vdma_mover #(
        .CNT_W (CNT_W)
    ) u_mover (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_addr  (start_addr),
        .start_bytes (start_bytes),
        .bus_rd_data (bus_rd_data),
        .busy        (busy),
        .bus_rd_en   (bus_rd_en),
        .bus_rd_addr (bus_rd_addr),
        .bus_wr_en   (bus_wr_en),
        .bus_wr_addr (bus_wr_addr),
        .bus_wr_data (bus_wr_data),
        .blk_done    (blk_done),
        .done_addr   (done_addr)
    );
endmodule

// File: rtl/vdma_checker.sv
// Protocol checker for the transfer engine, attached by bind below.
// Assumes the default-style layout: bursts are whole 16-byte multiples.
module vdma_checker
    import vdma_pkg::*;
#(
    parameter int unsigned       BLOCK_LOG2 = 4,
    parameter logic [ADDR_W-1:0] VRAM_BASE  = 16'h8000,
    parameter int unsigned       VRAM_LOG2  = 13
)(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [2:0]        reg_sel,
    input logic              cpu_stall,
    input logic              bus_rd_en,
    input logic [ADDR_W-1:0] bus_rd_addr,
    input logic              bus_wr_en,
    input logic [ADDR_W-1:0] bus_wr_addr,
    input logic [ADDR_W-1:0] src_word
);
    localparam logic [ADDR_W-1:0] SPAN_MASK = ADDR_W'((32'd1 << VRAM_LOG2) - 32'd1);

    logic [15:0] run_q;

    // Count consecutive stall cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (cpu_stall) begin
            run_q <= run_q + 16'd1;
        end else begin
            run_q <= '0;
        end
    end

    AST_READ_NEEDS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_en |-> cpu_stall); // R5
    AST_IDLE_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_stall |-> (!bus_rd_en && !bus_wr_en)); // R5
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_en |=> bus_wr_en); // R4
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd_en && bus_wr_en)); // R4
    AST_DST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && $past(bus_wr_en, 2)) |-> (bus_wr_addr == $past(bus_wr_addr, 2) + 16'd1)); // R4
    AST_BURST_WHOLE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_stall) |-> (run_q[BLOCK_LOG2:0] == '0)); // R3
    AST_FIRST_READ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && !$past(cpu_stall)) |-> (bus_rd_addr[BLOCK_LOG2-1:0] == '0)); // R1
    AST_REJECT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !cpu_stall && reg_sel == SEL_CTRL && (src_word & ~SPAN_MASK) == VRAM_BASE)
        |=> !cpu_stall); // R2
endmodule

bind vdma_engine vdma_checker #(
    .BLOCK_LOG2 (BLOCK_LOG2),
    .VRAM_BASE  (VRAM_BASE),
    .VRAM_LOG2  (VRAM_LOG2)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_sel     (reg_sel),
    .cpu_stall   (cpu_stall),
    .bus_rd_en   (bus_rd_en),
    .bus_rd_addr (bus_rd_addr),
    .bus_wr_en   (bus_wr_en),
    .bus_wr_addr (bus_wr_addr),
    .src_word    (src_word)
);

// File: tb/vdma_engine_test.sv
module vdma_engine_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [2:0]  reg_sel;
    logic [7:0]  reg_wdata;
    logic [2:0]  rd_sel;
    logic [7:0]  rd_data;
    logic [1:0]  video_mode;
    logic        lcd_on;
    logic        bus_rd_en;
    logic [15:0] bus_rd_addr;
    logic [7:0]  bus_rd_data = 8'h00;
    logic        bus_wr_en;
    logic [15:0] bus_wr_addr;
    logic [7:0]  bus_wr_data;
    logic        cpu_stall;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vdma_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
        .video_mode(video_mode), .lcd_on(lcd_on),
        .bus_rd_en(bus_rd_en), .bus_rd_addr(bus_rd_addr), .bus_rd_data(bus_rd_data),
        .bus_wr_en(bus_wr_en), .bus_wr_addr(bus_wr_addr), .bus_wr_data(bus_wr_data),
        .cpu_stall(cpu_stall)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    // Bus memory: registered read, data one cycle after the strobe
    always @(posedge clk) if (bus_rd_en) bus_rd_data <= pat(bus_rd_addr);

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_src, m_dst;
    logic [7:0]  m_reg [4];
    logic [7:0]  m_ctrl;
    int          m_left;
    int          m_phase;   // 0 idle, 1 read, 2 write
    bit          m_armed, m_prev0, m_enter;

    task automatic m_launch(input int nbytes);
        m_src   = {m_reg[0], m_reg[1]} & 16'hFFF0;
        m_dst   = ({m_reg[2], m_reg[3]} & 16'h1FF0) | 16'h8000;
        m_left  = nbytes;
        m_phase = 1;
    endtask

    task automatic m_ctrl_write(input logic [7:0] v);
        logic [15:0] s;
        bit was;
        s = {m_reg[0], m_reg[1]} & 16'hFFF0;
        if (s >= 16'h8000 && s < 16'hA000) begin
            m_ctrl = v | 8'h80;
        end else begin
            was = m_armed;
            m_armed = v[7];
            if ((!was && !v[7]) || video_mode == 2'd0) begin
                m_launch(v[7] ? 16 : (int'(v[6:0]) + 1) * 16);
                m_ctrl = v & 8'h7F;
            end else if (v[7] && !lcd_on) begin
                m_ctrl = 8'h80 | ((v + 8'd1) & 8'h7F);
            end else begin
                m_ctrl = v & 8'h7F;
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;
            m_ctrl = 8'hFF; m_armed = 0; m_phase = 0; m_left = 0;
            m_src = 0; m_dst = 0; m_prev0 = 1;
        end else begin
            m_enter = (video_mode == 2'd0) && !m_prev0;
            if (m_phase == 1) begin
                m_phase = 2;
            end else if (m_phase == 2) begin
                m_src++; m_dst++; m_left--;
                if (m_left == 0) begin
                    m_phase = 0;
                    m_reg[0] = m_src[15:8]; m_reg[1] = m_src[7:0];
                    m_reg[2] = m_dst[15:8]; m_reg[3] = m_dst[7:0];
                    if (m_armed) begin
                        m_ctrl = m_ctrl - 8'd1;
                        if (m_ctrl == 8'hFF) m_armed = 0;
                    end else begin
                        m_ctrl = 8'hFF;
                    end
                end else begin
                    m_phase = 1;
                end
            end else if (reg_wr && reg_sel == 3'd4) begin
                m_ctrl_write(reg_wdata);
            end else begin
                if (m_armed && m_enter) m_launch(16);
                if (reg_wr && reg_sel < 3'd4) m_reg[reg_sel[1:0]] = reg_wdata;
            end
            m_prev0 = (video_mode == 2'd0);
        end
    end

    // Per-cycle comparison, a quarter period after the edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n && !finished) begin
            chk("R5 stall", int'(cpu_stall), int'(m_phase != 0));
            chk("R4 read strobe", int'(bus_rd_en), int'(m_phase == 1));
            chk("R4 write strobe", int'(bus_wr_en), int'(m_phase == 2));
            if (m_phase == 1) chk("R4 read address", bus_rd_addr, m_src);
            if (m_phase == 2) begin
                chk("R4 write address", bus_wr_addr, m_dst);
                chk("R4 write data", bus_wr_data, pat(m_src));
            end
            if (rd_sel < 3'd4)       chk("R6 address readback", rd_data, m_reg[rd_sel[1:0]]);
            else if (rd_sel == 3'd4) chk("R9 control readback", rd_data, m_ctrl);
            else                     chk("R9 unused readback", rd_data, 8'hFF);
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic step(); @(negedge clk); endtask

    task automatic wr_reg(input logic [2:0] s, input logic [7:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [2:0] s, output int v);
        rd_sel = s; #1; v = rd_data;
    endtask

    task automatic count_stall(output int n);
        n = 0;
        while (cpu_stall && n < 10000) begin n++; step(); end
    endtask

    task automatic summary();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        int v, n;
        rst_n = 0; reg_wr = 0; reg_sel = 0; reg_wdata = 0; rd_sel = 3'd4;
        video_mode = 2'd1; lcd_on = 1'b1;
        repeat (3) step();
        // R10 reset state
        chk("R10 stall after reset", cpu_stall, 0);
        peek(3'd4, v); chk("R10 control after reset", v, 8'hFF);
        peek(3'd0, v); chk("R10 source high after reset", v, 8'h00);
        rst_n = 1; step();

        // General burst of 32 bytes, masked addresses
        wr_reg(3'd0, 8'h12); wr_reg(3'd1, 8'h3F); wr_reg(3'd2, 8'hE4); wr_reg(3'd3, 8'h27);
        wr_reg(3'd4, 8'h01);
        chk("R1 masked source", bus_rd_addr, 16'h1230);
        chk("R3 immediate start", cpu_stall, 1);
        step();
        chk("R1 masked destination", bus_wr_addr, 16'h8420);
        count_stall(n);
        chk("R3 general length in cycles", n + 1, 64);
        peek(3'd4, v); chk("R7 control after general", v, 8'hFF);
        peek(3'd0, v); chk("R6 source high written back", v, 8'h12);
        peek(3'd1, v); chk("R6 source low written back", v, 8'h50);
        peek(3'd2, v); chk("R6 dest high written back", v, 8'h84);
        peek(3'd3, v); chk("R6 dest low written back", v, 8'h40);

        // Rejected source inside video RAM
        wr_reg(3'd0, 8'h88); wr_reg(3'd1, 8'h00); wr_reg(3'd4, 8'h05);
        chk("R2 no burst on bad source", cpu_stall, 0);
        peek(3'd4, v); chk("R2 readback bit 7 set", v, 8'h85);
        peek(3'd0, v); chk("R2 source unchanged", v, 8'h88);
        step(); chk("R2 still idle", cpu_stall, 0);

        // Paced mode, two blocks
        wr_reg(3'd0, 8'h40); wr_reg(3'd1, 8'h00); wr_reg(3'd2, 8'h80); wr_reg(3'd3, 8'h00);
        video_mode = 2'd2; step();
        wr_reg(3'd4, 8'h81);
        chk("R8 no start outside blank", cpu_stall, 0);
        peek(3'd4, v); chk("R9 normal readback", v, 8'h01);
        video_mode = 2'd0; step();
        count_stall(n); chk("R8 first block length", n, 32);
        peek(3'd4, v); chk("R8 control decremented", v, 8'h00);
        video_mode = 2'd3; step(); step();
        video_mode = 2'd0; step();
        count_stall(n); chk("R8 second block length", n, 32);
        peek(3'd4, v); chk("R8 control wrapped", v, 8'hFF);
        peek(3'd1, v); chk("R6 paced source low", v, 8'h20);
        video_mode = 2'd3; step();
        video_mode = 2'd0; step(); step();
        chk("R8 disarmed after wrap", cpu_stall, 0);

        // LCD off request, then termination
        video_mode = 2'd1; lcd_on = 1'b0; step();
        wr_reg(3'd4, 8'h83);
        peek(3'd4, v); chk("R9 lcd-off readback", v, 8'h84);
        chk("R9 no start with lcd off", cpu_stall, 0);
        wr_reg(3'd4, 8'h00);
        chk("R11 termination starts nothing", cpu_stall, 0);
        peek(3'd4, v); chk("R11 termination readback", v, 8'h00);
        lcd_on = 1'b1;
        video_mode = 2'd0; step(); step();
        chk("R11 no block after termination", cpu_stall, 0);
        video_mode = 2'd1; step();

        // Writes during a burst are ignored
        wr_reg(3'd4, 8'h00);
        reg_wr = 1'b1; reg_sel = 3'd4; reg_wdata = 8'h7F;
        step();
        reg_wr = 1'b0;
        count_stall(n);
        chk("R12 burst not lengthened", n + 1, 32);
        peek(3'd4, v); chk("R12 control after ignored write", v, 8'hFF);

        // Paced request while already in blank starts at once
        video_mode = 2'd0; step(); step();
        wr_reg(3'd4, 8'h80);
        chk("R8 immediate block in blank", cpu_stall, 1);
        count_stall(n); chk("R8 immediate block length", n, 32);
        peek(3'd4, v); chk("R8 single block wraps", v, 8'hFF);
        video_mode = 2'd3; step();
        video_mode = 2'd0; step(); step();
        chk("R8 no further block", cpu_stall, 0);

        step();
        summary();
    end
endmodule